// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Jump

This block is the control half of a microcoded processor. A 512-entry control store holds 36-bit microinstructions. A microprogram counter selects the current word, and a microinstruction register holds it. Every cycle the register's control fields go to the datapath, and the sequencer works out the address of the following word.

There is no incrementer. Each microinstruction carries the address of its successor. That address can be altered in two ways. A latched negative or zero flag can set its top bit, which gives a two-way branch. The 8-bit opcode byte can be ORed into its low bits, which gives a multiway dispatch to the location equal to the opcode.

The control store is filled through a write port while the block is held in reset. The store is read continuously and has no read strobe.

Top module: `uSeqTop`

## Requirements
- R1: The word at the current address is split into fields, most significant first: successor address [35:27], dispatch enable [26], negative test [25], zero test [24], ALU/shift control [23:16], C-bus write mask [15:7], memory control [6:4], B-bus select [3:0]. The outputs `aluCtl`, `cMask`, `memCtl` and `bSel` always equal the fields of the word stored at `mpc`.
- R2: A cycle with `rst` high leaves `mpc` at 0, the register holding word 0, and both condition flags cleared. The flags read 0 even if `aluNeg`/`aluZero` are high during reset.
- R3: When bits [26:24] of the current word are 000, the next `mpc` equals the successor address field exactly. Consecutive words need not be at consecutive addresses.
- R4: When (bit 25 is set and the N flag is 1) or (bit 24 is set and the Z flag is 1), bit 8 of the next `mpc` is 1. Otherwise bit 8 is copied from the successor field.
- R5: When bit 26 is set, the low 8 bits of the next `mpc` are the successor field's low 8 bits ORed with `mbr`. When bit 26 is clear, they are the field's low 8 bits unchanged.
- R6: The dispatch and the flag test can be active in the same word. The results then combine: bit 8 comes from R4 and bits [7:0] come from R5.
- R7: Outside reset, the N and Z flags (`condN`, `condZ`) take `aluNeg` and `aluZero` at every clock edge. The word loaded at that same edge tests these flags.
- R8: A control-store write (`csWrEn` high) takes effect only in a cycle with `rst` high. A write made outside reset leaves the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables store writes |
| aluNeg | input | 1 | Datapath result negative |
| aluZero | input | 1 | Datapath result zero |
| mbr | input | 8 | Opcode byte used for dispatch |
| csWrEn | input | 1 | Control-store write enable |
| csWrAddr | input | 9 | Control-store write address |
| csWrData | input | 36 | Control-store write word |
| mpc | output | 9 | Microprogram counter |
| aluCtl | output | 8 | ALU and shifter control field |
| cMask | output | 9 | C-bus register write mask |
| memCtl | output | 3 | Memory control field |
| bSel | output | 4 | B-bus source select |
| condN | output | 1 | Latched negative flag |
| condZ | output | 1 | Latched zero flag |

## Verification
The assertions assume that every control-store word that can be reached was written during reset. They also assume that `mbr`, `aluNeg` and `aluZero` are known values in every cycle outside reset. The stimulus fills all 512 words before reset is released and drives every input at each falling edge. Branch and dispatch words are placed at chosen addresses. All other words fall back to address 0, so every path the run takes leads only to defined words.

// File: rtl/uSeqPkg.sv
package uSeqPkg;
  localparam int ADDR_W  = 9;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int OP_W    = 8;
  localparam int ALU_W   = 8;
  localparam int CMASK_W = 9;
  localparam int MEM_W   = 3;
  localparam int BSEL_W  = 4;
  localparam int JAM_W   = 3;
  localparam int WORD_W  = ADDR_W + JAM_W + ALU_W + CMASK_W + MEM_W + BSEL_W;

  typedef struct packed {
    logic [ADDR_W-1:0]  nextAddr;
    logic               jmpc;
    logic               jamN;
    logic               jamZ;
    logic [ALU_W-1:0]   alu;
    logic [CMASK_W-1:0] cMask;
    logic [MEM_W-1:0]   mem;
    logic [BSEL_W-1:0]  bSel;
  } uInstr_t;

  typedef struct packed {
    logic forceHigh;
    logic orOpcode;
  } seqStrobe_t;
endpackage

// File: rtl/uSeqStore.sv
module uSeqStore
  import uSeqPkg::*;
(
  input  logic              clk,
  input  logic              wrAllow,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn && wrAllow) cells[wrAddr] <= wrData;
  end

  assign rdData = cells[rdAddr];
endmodule

// File: rtl/uSeqCtl.sv
module uSeqCtl
  import uSeqPkg::*;
(
  input  uInstr_t    mir,
  input  logic       nFlag,
  input  logic       zFlag,
  output seqStrobe_t strobe
);
  always_comb begin
    strobe.forceHigh = (mir.jamN && nFlag) || (mir.jamZ && zFlag);
    strobe.orOpcode  = mir.jmpc;
  end
endmodule

// File: rtl/uSeqPath.sv
module uSeqPath
  import uSeqPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              aluNeg,
  input  logic              aluZero,
  input  logic [OP_W-1:0]   mbr,
  input  seqStrobe_t        strobe,
  input  logic [WORD_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output uInstr_t           mir,
  output logic [ADDR_W-1:0] mpc,
  output logic              nFlag,
  output logic              zFlag
);
  localparam int LOW_W = ADDR_W - 1;

  logic [LOW_W-1:0]  opExt;
  logic [ADDR_W-1:0] nextAddr;

  assign opExt = strobe.orOpcode ? LOW_W'(mbr) : '0;

  always_comb begin
    nextAddr[ADDR_W-1]  = mir.nextAddr[ADDR_W-1] | strobe.forceHigh;
    nextAddr[LOW_W-1:0] = mir.nextAddr[LOW_W-1:0] | opExt;
  end

  assign rdAddr = rst ? '0 : nextAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mpc   <= '0;
      mir   <= uInstr_t'(rdData);
      nFlag <= 1'b0;
      zFlag <= 1'b0;
    end else begin
      mpc   <= nextAddr;
      mir   <= uInstr_t'(rdData);
      nFlag <= aluNeg;
      zFlag <= aluZero;
    end
  end
endmodule

// File: rtl/uSeqTop.sv
module uSeqTop
  import uSeqPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               aluNeg,
  input  logic               aluZero,
  input  logic [OP_W-1:0]    mbr,
  input  logic               csWrEn,
  input  logic [ADDR_W-1:0]  csWrAddr,
  input  logic [WORD_W-1:0]  csWrData,
  output logic [ADDR_W-1:0]  mpc,
  output logic [ALU_W-1:0]   aluCtl,
  output logic [CMASK_W-1:0] cMask,
  output logic [MEM_W-1:0]   memCtl,
  output logic [BSEL_W-1:0]  bSel,
  output logic               condN,
  output logic               condZ
);
  uInstr_t           mir;
  seqStrobe_t        strobe;
  logic [ADDR_W-1:0] rdAddr;
  logic [WORD_W-1:0] rdData;

  uSeqStore u_store (
    .clk(clk), .wrAllow(rst), .wrEn(csWrEn), .wrAddr(csWrAddr),
    .wrData(csWrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  uSeqCtl u_ctl (
    .mir(mir), .nFlag(condN), .zFlag(condZ), .strobe(strobe)
  );

  uSeqPath u_path (
    .clk(clk), .rst(rst), .aluNeg(aluNeg), .aluZero(aluZero), .mbr(mbr),
    .strobe(strobe), .rdData(rdData), .rdAddr(rdAddr), .mir(mir),
    .mpc(mpc), .nFlag(condN), .zFlag(condZ)
  );

  assign aluCtl = mir.alu;
  assign cMask  = mir.cMask;
  assign memCtl = mir.mem;
  assign bSel   = mir.bSel;
endmodule

// File: rtl/uSeqChecker.sv
module uSeqChecker
  import uSeqPkg::*;
(
  input logic              clk,
  input logic              rst,
  input uInstr_t           mir,
  input logic [ADDR_W-1:0] mpc,
  input logic              nFlag,
  input logic              zFlag,
  input logic [OP_W-1:0]   mbr,
  input logic              aluNeg,
  input logic              aluZero
);
  localparam int LOW_W = ADDR_W - 1;

  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (mpc == '0 && !nFlag && !zFlag));

  a_r3_plain_next: assert property (@(posedge clk) disable iff (rst)
    (!mir.jmpc && !mir.jamN && !mir.jamZ) |=> mpc == $past(mir.nextAddr));

  a_r4_high_bit: assert property (@(posedge clk) disable iff (rst)
    ((mir.jamN && nFlag) || (mir.jamZ && zFlag)) |=> mpc[ADDR_W-1]);

  a_r4_high_copy: assert property (@(posedge clk) disable iff (rst)
    (!(mir.jamN && nFlag) && !(mir.jamZ && zFlag))
      |=> mpc[ADDR_W-1] == $past(mir.nextAddr[ADDR_W-1]));

  a_r5_dispatch_low: assert property (@(posedge clk) disable iff (rst)
    mir.jmpc |=> mpc[LOW_W-1:0] ==
      ($past(mir.nextAddr[LOW_W-1:0]) | LOW_W'($past(mbr))));

  a_r5_no_dispatch: assert property (@(posedge clk) disable iff (rst)
    !mir.jmpc |=> mpc[LOW_W-1:0] == $past(mir.nextAddr[LOW_W-1:0]));

  a_r7_flag_latch: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (nFlag == $past(aluNeg) && zFlag == $past(aluZero)));
endmodule

bind uSeqPath uSeqChecker u_chk (
  .clk(clk), .rst(rst), .mir(mir), .mpc(mpc), .nFlag(nFlag),
  .zFlag(zFlag), .mbr(mbr), .aluNeg(aluNeg), .aluZero(aluZero)
);

// File: tb/uSeqTop_tb.sv
`timescale 1ns/1ps
module uSeqTop_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        aluNeg = 1'b0, aluZero = 1'b0;
  logic [7:0]  mbr = '0;
  logic        csWrEn = 1'b0;
  logic [8:0]  csWrAddr = '0;
  logic [35:0] csWrData = '0;
  logic [8:0]  mpc;
  logic [7:0]  aluCtl;
  logic [8:0]  cMask;
  logic [2:0]  memCtl;
  logic [3:0]  bSel;
  logic        condN, condZ;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uSeqTop u_dut (
    .clk(clk), .rst(rst), .aluNeg(aluNeg), .aluZero(aluZero), .mbr(mbr),
    .csWrEn(csWrEn), .csWrAddr(csWrAddr), .csWrData(csWrData), .mpc(mpc),
    .aluCtl(aluCtl), .cMask(cMask), .memCtl(memCtl), .bSel(bSel),
    .condN(condN), .condZ(condZ)
  );

  // {mbr, aluNeg, aluZero, expected mpc after the edge}
  localparam logic [18:0] VEC [30] = '{
    {8'h00,1'b0,1'b1,9'h005}, {8'h00,1'b0,1'b0,9'h110}, {8'h00,1'b0,1'b0,9'h000},
    {8'h00,1'b0,1'b0,9'h005}, {8'h00,1'b1,1'b0,9'h010}, {8'h00,1'b0,1'b1,9'h120},
    {8'h00,1'b0,1'b0,9'h130}, {8'h00,1'b0,1'b0,9'h000}, {8'h00,1'b0,1'b0,9'h005},
    {8'h00,1'b0,1'b0,9'h010}, {8'h00,1'b0,1'b0,9'h020}, {8'h60,1'b0,1'b0,9'h160},
    {8'h00,1'b0,1'b0,9'h000}, {8'h00,1'b0,1'b0,9'h005}, {8'h00,1'b0,1'b0,9'h010},
    {8'h00,1'b0,1'b0,9'h020}, {8'hFF,1'b0,1'b0,9'h1FF}, {8'h00,1'b0,1'b0,9'h000},
    {8'h00,1'b0,1'b0,9'h005}, {8'h00,1'b1,1'b0,9'h010}, {8'h00,1'b0,1'b0,9'h120},
    {8'h00,1'b0,1'b1,9'h030}, {8'h0A,1'b0,1'b0,9'h14A}, {8'h00,1'b0,1'b0,9'h000},
    {8'h00,1'b0,1'b0,9'h005}, {8'h00,1'b1,1'b0,9'h010}, {8'h00,1'b0,1'b0,9'h120},
    {8'h00,1'b0,1'b0,9'h030}, {8'h45,1'b0,1'b0,9'h045}, {8'h00,1'b0,1'b0,9'h000}
  };

  // Word layout (R1): {next[8:0], jmpc, jamN, jamZ, alu[7:0], cMask[8:0], mem[2:0], bSel[3:0]}
  function automatic logic [35:0] progWord(input logic [8:0] a);
    logic [8:0] nxt;
    logic [2:0] jam;
    case (a)
      9'h000:  begin nxt = 9'h005; jam = 3'b000; end
      9'h005:  begin nxt = 9'h010; jam = 3'b001; end
      9'h010:  begin nxt = 9'h020; jam = 3'b010; end
      9'h120:  begin nxt = 9'h030; jam = 3'b011; end
      9'h020:  begin nxt = 9'h100; jam = 3'b100; end
      9'h030:  begin nxt = 9'h040; jam = 3'b111; end
      default: begin nxt = 9'h000; jam = 3'b000; end
    endcase
    return {nxt, jam, a[7:0] ^ 8'h5A, ~a, a[2:0], a[3:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkFields(input string req, input logic [35:0] w);
    logic [35:0] act;
    act = {w[35:24], aluCtl, cMask, memCtl, bSel};
    check(act == w, req, act, w);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // Fill the store during reset (R8)
    for (int a = 0; a < 512; a++) begin
      csWrEn = 1'b1; csWrAddr = 9'(a); csWrData = progWord(9'(a));
      step();
    end
    csWrEn = 1'b0;
    aluNeg = 1'b1; aluZero = 1'b1;
    step(); step();
    // R2: reset state
    check(mpc == 9'h000, "R2 mpc", 36'(mpc), 36'h0);
    check(condN == 1'b0 && condZ == 1'b0, "R2 flags", 36'({condN, condZ}), 36'h0);
    checkFields("R1 reset word", progWord(9'h000));
    aluNeg = 1'b0; aluZero = 1'b0;

    rst = 1'b0;
    // R3 R4 R5 R6 R7: vector walk
    for (int i = 0; i < 30; i++) begin
      mbr = VEC[i][18:11]; aluNeg = VEC[i][10]; aluZero = VEC[i][9];
      step();
      check(mpc == VEC[i][8:0], "R3/R4/R5/R6 next mpc", 36'(mpc), 36'(VEC[i][8:0]));
      checkFields("R1 fields", progWord(VEC[i][8:0]));
      check(condN == VEC[i][10] && condZ == VEC[i][9], "R7 flags",
            36'({condN, condZ}), 36'({VEC[i][10], VEC[i][9]}));
    end

    // R8: write outside reset has no effect
    mbr = '0; aluNeg = 1'b1; aluZero = 1'b1;
    csWrEn = 1'b1; csWrAddr = 9'h000;
    csWrData = {9'h0AB, 3'b000, 8'hC3, 9'h111, 3'b101, 4'h9};
    step();
    csWrEn = 1'b0;
    rst = 1'b1;
    step(); step();
    checkFields("R8 ignored write", progWord(9'h000));
    check(condN == 1'b0 && condZ == 1'b0, "R2 flags cleared", 36'({condN, condZ}), 36'h0);
    check(mpc == 9'h000, "R2 mpc after run", 36'(mpc), 36'h0);

    // R8: write during reset takes effect
    csWrEn = 1'b1;
    step();
    csWrEn = 1'b0;
    step();
    checkFields("R8 reset write", csWrData);
    aluNeg = 1'b0; aluZero = 1'b0;
    rst = 1'b0;
    step();
    check(mpc == 9'h0AB, "R3 non-sequential successor", 36'(mpc), 36'h0AB);
    checkFields("R1 default word", progWord(9'h0AB));
    step();
    check(mpc == 9'h000, "R3 return to zero", 36'(mpc), 36'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule